// File: doc/BRIEF.md
# Serial SAR Converter Control Logic

This block is the digital sequencer of an eight-input successive-approximation converter. It sits behind a four-wire synchronous serial port. The bit clock from the host also drives the conversion, so there is no separate conversion clock. A command byte arrives MSB first and is framed by a leading 1. It selects the input channel, single-ended or differential operation and a power-down code.

When the command byte is complete, the block raises a busy flag for one bit clock while the top trial bit is weighed. It then makes one comparator decision per bit clock. Each decided bit is presented on the serial output straight away, so the result leaves MSB first. Any further bit clocks shift out zeros. A host that reads in bytes can start the next command in the same clock that carries the LSB, which gives 24 clocks per conversion. A host can also use a relaxed 32-clock frame that ends in seven zeros.

The block gives the analog side the channel code, the input mode, the power-down code, the running trial DAC code and an acquisition flag. It reads back one comparator bit. All port inputs pass through a synchronizer in the fabric clock `clk`, and the block acts on the detected edges of the bit clock. The outputs are registered.

Top module: `sar_serial_ctl`

## Requirements
- R1: After synchronous reset, `dout_oe_o`, `busy_oe_o`, `busy_o`, `dout_o`, `acq_o` and `dac_code_o` are all zero.
- R2: While `cs_n_i` is high, both output enables are low and `dout_o` and `busy_o` are 0. Once `cs_n_i` is low, both enables are high and `busy_o` is low outside the conversion clock.
- R3: With chip select low and the block idle, DIN zeros are ignored until a 1 is sampled on a rising bit-clock edge. That 1 is taken as the start bit. DIN is also ignored during the busy clock and the data bits, except in the LSB clock.
- R4: The command byte is sampled MSB first on rising edges. Bit 7 is the start bit. Bits 6:4 form the channel code on `chan_o`. Bit 3 is ignored. Bit 2 drives `single_o` (1 means single-ended). Bits 1:0 drive `pd_o`.
- R5: `busy_o` goes high on the falling edge of the clock that carried command bit 8. It stays high for exactly one bit clock.
- R6: On each of the 16 falling edges after the busy clock, `dout_o` takes the next result bit, D15 first and D0 last. The bit is 1 when the comparator input sampled at that edge is 1. At the end, `dac_code_o` holds the full result.
- R7: Falling edges after D0 drive `dout_o` to 0. In a 32-clock frame, the last seven clocks read zeros.
- R8: A start bit sampled in the clock that presents D0 begins a new command. D0 stays on `dout_o` until the next falling edge, and back-to-back conversions then take 24 clocks each.
- R9: Raising `cs_n_i` in the middle of a command or a readout abandons the frame. A later frame with chip select low then runs normally.
- R10: During the busy clock `dac_code_o` equals 0x8000. At each decision the trial bit is kept when the comparator reads 1 and cleared when it reads 0, and the next lower bit is set as the new trial.
- R11: `acq_o` is high from the rising edge that takes command bit 4 (the last channel bit) until the rising edge that takes bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples every port input |
| rst | input | 1 | Synchronous active-high reset |
| dclk_i | input | 1 | Serial bit clock from the host |
| cs_n_i | input | 1 | Active-low chip select |
| din_i | input | 1 | Serial command input |
| cmp_i | input | 1 | Comparator decision, 1 when the input is at or above the trial DAC code |
| dout_o | output | 1 | Serial result output |
| dout_oe_o | output | 1 | Output enable for the serial result pad |
| busy_o | output | 1 | Conversion flag |
| busy_oe_o | output | 1 | Output enable for the busy pad |
| chan_o | output | CH_W | Channel selection for the input multiplexer |
| single_o | output | 1 | 1 = single-ended input, 0 = differential |
| pd_o | output | PD_W | Power-down code |
| dac_code_o | output | DATA_W | Trial code for the capacitor DAC |
| acq_o | output | 1 | Sampling switch closed (acquisition window) |

## Verification
Several rules are checked on every cycle. Busy never outlives one falling bit-clock edge. Outputs stay quiet while their enables are low. Idle keeps the serial output at zero. A chip-select release always returns the sequencer to idle. Each SAR step keeps or drops its trial bit according to the comparator, and only one trial bit is ever live. Only the bench scenarios can show the frame-level results. These are the exact bit-clock position of busy and of each result bit for a modelled analog input, the field positions of the command byte, and DIN being ignored before the start bit and during readout. They also cover the 24-clock overlapped chaining, the zero fill and recovery after an abort mid-command or mid-readout.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start bit
    ST_CMD,    // collecting the command byte
    ST_WAIT,   // byte done, waiting for the busy falling edge
    ST_CONV,   // busy clock: MSB trial under way
    ST_DATA    // shifting decided bits
  } seq_state_e;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] last_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= RST_VAL;
    else     last_q <= pipe[STAGES-1];
  end

  assign q_o    = pipe[STAGES-1];
  assign rise_o = pipe[STAGES-1] & ~last_q;
  assign fall_o = ~pipe[STAGES-1] & last_q;

endmodule

// File: rtl/sar_cmd_rx.sv
module sar_cmd_rx #(
  parameter int CH_W = 3,
  parameter int PD_W = 2,
  localparam int CMD_W = CH_W + PD_W + 3,
  localparam int CNT_W = $clog2(CMD_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             start,
  input  logic             shift,
  input  logic             bit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             single_o,
  output logic [PD_W-1:0]  pd_o
);

  // bit count after which each field is complete
  localparam int CH_DONE  = 1 + CH_W;
  localparam int SGL_DONE = CH_DONE + 2;

  logic [CMD_W-1:0] sh_q;
  logic [CMD_W:0]   nxt;

  assign nxt = {sh_q, bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      cnt_o    <= '0;
      chan_o   <= '0;
      single_o <= 1'b0;
      pd_o     <= '0;
    end else if (clr) begin
      cnt_o <= '0;
    end else if (start) begin
      sh_q  <= CMD_W'(1);
      cnt_o <= CNT_W'(1);
    end else if (shift) begin
      sh_q  <= nxt[CMD_W-1:0];
      cnt_o <= cnt_o + CNT_W'(1);
      if (cnt_o == CNT_W'(CH_DONE - 1))  chan_o   <= nxt[CH_W-1:0];
      if (cnt_o == CNT_W'(SGL_DONE - 1)) single_o <= bit_i;
      if (cnt_o == CNT_W'(CMD_W - 1))    pd_o     <= nxt[PD_W-1:0];
    end
  end

endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic              step,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] dac_o
);

  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] trial_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      trial_q <= '0;
      dac_o   <= '0;
    end else if (load) begin
      trial_q <= TOP_BIT;
      dac_o   <= TOP_BIT;
    end else if (step) begin
      dac_o   <= (cmp_i ? dac_o : (dac_o & ~trial_q)) | (trial_q >> 1);
      trial_q <= trial_q >> 1;
    end
  end

  p_one_trial_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trial_q));

  p_keep_bit_r10: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !clr && cmp_i) |=> ((dac_o & $past(trial_q)) == $past(trial_q)));

  p_drop_bit_r10: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !clr && !cmp_i) |=> ((dac_o & $past(trial_q)) == '0));

endmodule

// File: rtl/sar_serial_ctl.sv
module sar_serial_ctl
  import sar_ctl_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CH_W        = 3,
  parameter int PD_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dclk_i,
  input  logic              cs_n_i,
  input  logic              din_i,
  input  logic              cmp_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              busy_o,
  output logic              busy_oe_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              single_o,
  output logic [PD_W-1:0]   pd_o,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              acq_o
);

  localparam int CMD_W   = CH_W + PD_W + 3;
  localparam int CNT_W   = $clog2(CMD_W + 1);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int CH_DONE = 1 + CH_W;

  // synchronized port inputs: {cs_n, dclk, din, cmp}
  logic [3:0] s_q, s_rise, s_fall;
  logic cs_s, din_s, cmp_s, r_e, f_e;

  sar_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({cs_n_i, dclk_i, din_i, cmp_i}),
    .q_o(s_q), .rise_o(s_rise), .fall_o(s_fall)
  );

  assign cs_s  = s_q[3];
  assign din_s = s_q[1];
  assign cmp_s = s_q[0];
  assign r_e   = s_rise[2] & ~cs_s;
  assign f_e   = s_fall[2] & ~cs_s;

  seq_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cmd_cnt, cnt_nxt;
  logic cmd_start, cmd_shift, core_load, core_step;

  assign cmd_start = r_e && din_s &&
                     ((st_q == ST_IDLE) || (st_q == ST_DATA && idx_q == '0));
  assign cmd_shift = r_e && (st_q == ST_CMD);
  assign core_load = f_e && (st_q == ST_WAIT);
  assign core_step = f_e && ((st_q == ST_CONV) || (st_q == ST_DATA && idx_q != '0));
  assign cnt_nxt   = cmd_cnt + CNT_W'(1);

  sar_cmd_rx #(.CH_W(CH_W), .PD_W(PD_W)) u_cmd (
    .clk(clk), .rst(rst), .clr(cs_s),
    .start(cmd_start), .shift(cmd_shift), .bit_i(din_s),
    .cnt_o(cmd_cnt), .chan_o(chan_o), .single_o(single_o), .pd_o(pd_o)
  );

  sar_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .clr(cs_s),
    .load(core_load), .step(core_step), .cmp_i(cmp_s),
    .dac_o(dac_code_o)
  );

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      st_q      <= ST_IDLE;
      dout_o    <= 1'b0;
      busy_o    <= 1'b0;
      dout_oe_o <= 1'b0;
      busy_oe_o <= 1'b0;
      idx_q     <= '0;
      acq_o     <= 1'b0;
    end else begin
      dout_oe_o <= 1'b1;
      busy_oe_o <= 1'b1;
      if (cmd_start)
        acq_o <= 1'b0;
      else if (cmd_shift)
        acq_o <= (cnt_nxt >= CNT_W'(CH_DONE)) && (cnt_nxt < CNT_W'(CMD_W));
      unique case (st_q)
        ST_IDLE: if (cmd_start) st_q <= ST_CMD;
        ST_CMD: begin
          if (cmd_shift && cmd_cnt == CNT_W'(CMD_W - 1)) st_q <= ST_WAIT;
          if (f_e) dout_o <= 1'b0;
        end
        ST_WAIT: if (f_e) begin
          busy_o <= 1'b1;
          st_q   <= ST_CONV;
        end
        ST_CONV: if (f_e) begin
          busy_o <= 1'b0;
          dout_o <= cmp_s;
          idx_q  <= IDX_W'(DATA_W - 1);
          st_q   <= ST_DATA;
        end
        ST_DATA: begin
          if (cmd_start) begin
            st_q <= ST_CMD;
          end else if (f_e) begin
            if (idx_q == '0) begin
              dout_o <= 1'b0;
              st_q   <= ST_IDLE;
            end else begin
              dout_o <= cmp_s;
              idx_q  <= idx_q - IDX_W'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_busy_has_oe_r2: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> busy_oe_o);

  p_hiz_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !dout_oe_o |-> (!dout_o && !busy_o));

  p_busy_one_clock_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && f_e) |=> !busy_o);

  p_msb_from_cmp_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CONV && f_e) |=> (dout_o == $past(cmp_s)));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> !dout_o);

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (st_q == ST_IDLE && !dout_oe_o && !acq_o));

endmodule

// File: tb/sim_sar_serial_ctl.sv
module sim_sar_serial_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_CLKS  = 16;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic [15:0] vana = 16'h0000;
  logic dout, dout_oe, busy, busy_oe, single, acq, cmp;
  logic [2:0] chan;
  logic [1:0] pd;
  logic [15:0] dac;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp = (vana >= dac);

  sar_serial_ctl u0 (
    .clk(clk), .rst(rst), .dclk_i(dclk), .cs_n_i(cs_n), .din_i(din),
    .cmp_i(cmp), .dout_o(dout), .dout_oe_o(dout_oe), .busy_o(busy),
    .busy_oe_o(busy_oe), .chan_o(chan), .single_o(single), .pd_o(pd),
    .dac_code_o(dac), .acq_o(acq)
  );

  typedef struct {
    logic  d;
    logic  b;
    logic  oe;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  event smp;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: pops one expected item per sampled bit clock
  always @(smp) begin
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk({dout, busy, dout_oe, busy_oe} === {e.d, e.b, e.oe, e.oe}, e.tag,
          "dout/busy/dout_oe/busy_oe", {dout, busy, dout_oe, busy_oe},
          {e.d, e.b, e.oe, e.oe});
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit clock; samples outputs mid-way through the high phase
  task automatic bit_clock(input logic d, input bit check, input logic ed,
                           input logic eb, input logic eoe, input string tag,
                           output logic [15:0] s_dac, output logic s_acq);
    @(negedge clk);
    din = d;
    wait_clk(HALF_CLKS);
    dclk = 1'b1;
    wait_clk(HALF_CLKS/2);
    s_dac = dac;
    s_acq = acq;
    if (check) begin
      exp_q.push_back('{ed, eb, eoe, tag});
      -> smp;
    end
    wait_clk(HALF_CLKS/2);
    dclk = 1'b0;
  endtask

  // frame A starts after 'lead' idle clocks; frame B (if s1>0) starts in A's clock s1
  task automatic run_seq(input int lead, input int s1, input int total,
                         input logic [7:0] ca, input logic [15:0] va,
                         input logic [7:0] cb, input logic [15:0] vb,
                         input bit noise);
    for (int g = 1; g <= total; g++) begin
      int ka, kb, k;
      logic d, ed, eb, sa;
      logic [15:0] vv, sd;
      string tag;
      ka = g - lead;
      kb = (s1 > 0) ? ka - s1 + 1 : -100;
      if (kb >= 1 && kb <= 8)                   d = cb[8-kb];
      else if (ka >= 1 && ka <= 8)              d = ca[8-ka];
      else if (noise && ka >= 10 && ka <= 24)   d = 1'b1;
      else                                      d = 1'b0;
      vana = (kb >= 1) ? vb : va;
      k  = (kb >= 2) ? kb : ka;
      vv = (kb >= 2) ? vb : va;
      ed = 1'b0; eb = 1'b0; tag = "R3";
      if (k == 9) begin
        eb = 1'b1; tag = "R5";
      end else if (k >= 10 && k <= 25) begin
        ed = vv[25-k]; tag = (s1 > 0) ? "R8" : "R6";
      end else if (k > 25) begin
        tag = "R7";
      end
      bit_clock(d, 1'b1, ed, eb, 1'b1, tag, sd, sa);
      if (kb < 1) begin
        if (ka == 9)  chk(sd == 16'h8000, "R10", "trial code in busy clock", sd, 16'h8000);
        if (ka == 10) chk(sd == {va[15], 1'b1, 14'b0}, "R10", "second trial code",
                          sd, {va[15], 1'b1, 14'b0});
        if (ka == 3)  chk(sa == 1'b0, "R11", "acq before channel", sa, 0);
        if (ka == 4)  chk(sa == 1'b1, "R11", "acq after channel", sa, 1);
        if (ka == 7)  chk(sa == 1'b1, "R11", "acq at bit 7", sa, 1);
        if (ka == 8)  chk(sa == 1'b0, "R11", "acq after byte", sa, 0);
      end
    end
  endtask

  task automatic chk_cmd(input logic [7:0] c, input logic [15:0] v);
    chk(chan == c[6:4], "R4", "channel", chan, c[6:4]);
    chk(single == c[2], "R4", "single", single, c[2]);
    chk(pd == c[1:0], "R4", "power-down", pd, c[1:0]);
    chk(dac == v, "R6", "final dac code", dac, v);
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(6);
    chk(dout_oe && busy_oe && !busy, "R2", "enables after CS low",
        {dout_oe, busy_oe, busy}, 3'b110);
  endtask

  task automatic cs_high(input string tag);
    logic [15:0] sd;
    logic sa;
    @(negedge clk);
    cs_n = 1'b1;
    wait_clk(6);
    chk({dout_oe, busy_oe, dout, busy} == 4'b0000, tag, "hi-Z after CS high",
        {dout_oe, busy_oe, dout, busy}, 0);
    for (int i = 0; i < 3; i++) bit_clock(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2", sd, sa);
  endtask

  // partial frame then CS release
  task automatic abort_after(input logic [7:0] c, input int n);
    logic [15:0] sd;
    logic sa;
    for (int k = 1; k <= n; k++)
      bit_clock((k <= 8) ? c[8-k] : 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9", sd, sa);
    cs_high("R9");
  endtask

  initial begin
    wait_clk(5);
    @(negedge clk);
    rst = 1'b0;
    wait_clk(4);
    chk({dout_oe, busy_oe, busy, dout, acq} == 5'b0, "R1", "reset outputs",
        {dout_oe, busy_oe, busy, dout, acq}, 0);
    chk(dac == 16'h0, "R1", "reset dac", dac, 0);

    cs_high("R2");
    cs_low();

    // leading zeros, DIN noise during readout, 32-clock frame
    vana = 16'hA5C3;
    run_seq(3, 0, 35, 8'b1101_0110, 16'hA5C3, 8'h00, 16'h0, 1'b1);
    chk_cmd(8'b1101_0110, 16'hA5C3);

    // overlapped frames: start of B rides on A's LSB clock
    run_seq(1, 25, 24 + 25 + 7, 8'b1010_0001, 16'h0001, 8'b1111_1111, 16'hFFFF, 1'b0);
    chk_cmd(8'b1111_1111, 16'hFFFF);

    // all-zero result
    run_seq(0, 0, 30, 8'b1000_0100, 16'h0000, 8'h00, 16'h0, 1'b0);
    chk_cmd(8'b1000_0100, 16'h0000);

    // abort mid-command, then mid-readout, recovering each time
    abort_after(8'b1011_0111, 5);
    cs_low();
    run_seq(2, 0, 32, 8'b1011_0010, 16'h7FFF, 8'h00, 16'h0, 1'b0);
    chk_cmd(8'b1011_0010, 16'h7FFF);
    vana = 16'h1234;
    abort_after(8'b1110_0101, 15);
    cs_low();
    run_seq(1, 0, 32, 8'b1001_0011, 16'h8001, 8'h00, 16'h0, 1'b1);
    chk_cmd(8'b1001_0011, 16'h8001);

    wait_clk(4);
    chk(exp_q.size() == 0, "R6", "monitor drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all-requirements actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule